// File: doc/BRIEF.md
# One's-Complement Accumulator ALU

This block is the arithmetic and logic stage of a 12-bit accumulator machine. Each operation takes four inputs: the current accumulator, an operand word, the link bit and a 4-bit operation code, presented together with a one-cycle start strobe. One clock edge later the block presents registered results. These are the new accumulator, the new link, the overflow flag, a memory write-back word with its enable, and a skip request for the sequencer. Address generation, instruction decoding and the memory itself belong to the surrounding core.

Additions come in two kinds. Plain adds use one's-complement arithmetic with end-around carry. The link-add is a two-step two's-complement sum that moves the carry into the link. The logic group clears, sets or flips accumulator bits under the operand. The test group compares the accumulator with the operand, or rotates the operand while testing its least significant bit. Both tests report through the skip request. The overflow flag is the block's only state that lasts across operations: operations that do not add leave it as it was.

Word bit numbering: index [11] of every port is the sign (most significant) bit, and index [0] is the least significant bit.

Top module: `oc_alu12`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is zero.
- R2: Op code 0 (one's-complement add) sets the accumulator to acc + operand. If the 12-bit sum carries out, 1 is added to the sum (end-around carry). The link output equals the link input, and the write-back enable stays low.
- R3: For op codes 0 and 1, the overflow flag becomes 1 when both addends have the same sign bit and the result has the other sign bit, and 0 otherwise. Op codes 3 to 15 leave the flag at its previous value.
- R4: Op code 1 (add to memory) performs the R2 sum. It writes that sum both to the accumulator and to the write-back word, with the write-back enable high.
- R5: Op code 2 (link-add) first forms acc + link in two's complement; the link takes that step's carry, which can clear it. It then adds the operand in two's complement. A carry from this second step sets the link; with no carry the link keeps its first-step value. The final sum goes to both the accumulator and the write-back word. The overflow flag follows the R3 sign rule applied to the second step.
- R6: Op codes 3, 4 and 5 set the accumulator to acc AND NOT operand, acc OR operand, and acc XOR operand respectively. There is no write-back and no skip, and the link passes through unchanged.
- R7: Op code 6 (equality test) raises the skip request exactly when the accumulator equals the operand. The accumulator passes through unchanged, and there is no write-back.
- R8: Op code 7 (test and rotate) raises the skip request exactly when operand bit [0] is 0. It always writes back the operand rotated right by one place, with bit [0] moving into bit [11]. The accumulator passes through unchanged.
- R9: Results appear in the cycle after `start` is sampled high. `done`, `wb_en` and `skip` are high only in that cycle. Without `start`, all registered outputs hold their values.
- R10: Op codes 8 to 15 pass the accumulator and link through, leave the overflow flag unchanged, raise neither write-back nor skip, and still pulse `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one operation using the inputs sampled this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 12 | Current accumulator |
| opnd_in | input | 12 | Operand word |
| link_in | input | 1 | Current link bit |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link bit |
| ovf_out | output | 1 | Overflow flag |
| wb_data | output | 12 | Memory write-back word |
| wb_en | output | 1 | Write-back enable, one-cycle pulse |
| skip | output | 1 | Skip request, one-cycle pulse |
| done | output | 1 | Result-valid pulse |

## Verification
The bench goes after the end-around carry: 7777 + 0001 must give 0001, and a design without the wrap would return 0000. It tests overflow in three ways. Two negative addends whose sum wraps to a positive value must set the flag. Addends of unlike sign must clear it. A logic operation must leave it untouched, where a careless design would clear it. For the link-add, the bench covers a first step that clears a set link while the second step has no carry, a second step that sets the link, and a second step with no carry that must keep the link set. A design that ORs the incoming link, or recomputes the link only once, returns the wrong link in one of these cases. For the rotate test, the bench checks that the skip follows the operand bit before the rotation, and that the write-back, skip and done pulses fall after one cycle.

// File: rtl/oc_alu12_pkg.sv
package oc_alu12_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDM = 4'd1,
    OP_LADD = 4'd2,
    OP_CLR  = 4'd3,
    OP_SET  = 4'd4,
    OP_FLIP = 4'd5,
    OP_EQ   = 4'd6,
    OP_ROT  = 4'd7
  } alu_op_e;
endpackage

// File: rtl/oc_adder.sv
// One's-complement adder with end-around carry and sign-based overflow.
module oc_adder #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0] raw;
  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/link_adder.sv
// Two-step two's-complement add through the link bit.
module link_adder #(
  parameter int W = 12
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         link_i,
  output logic [W-1:0] sum,
  output logic         link_o,
  output logic         ovf
);
  logic [W:0] step1;
  logic [W:0] step2;
  always_comb begin
    step1  = {1'b0, acc} + {{W{1'b0}}, link_i};
    step2  = {1'b0, step1[W-1:0]} + {1'b0, opnd};
    sum    = step2[W-1:0];
    link_o = step2[W] ? 1'b1 : step1[W];
    ovf    = (step1[W-1] == opnd[W-1]) && (step2[W-1] != opnd[W-1]);
  end
endmodule

// File: rtl/bit_unit.sv
// Bitwise group, equality test and rotate test.
module bit_unit
  import oc_alu12_pkg::*;
#(
  parameter int W = 12
) (
  input  alu_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         eq,
  output logic [W-1:0] rot,
  output logic         rot_skip
);
  always_comb begin
    unique case (op)
      OP_CLR:  res = acc & ~opnd;
      OP_SET:  res = acc | opnd;
      OP_FLIP: res = acc ^ opnd;
      default: res = acc;
    endcase
    eq       = (acc == opnd);
    rot      = {opnd[0], opnd[W-1:1]};
    rot_skip = ~opnd[0];
  end
endmodule

// File: rtl/oc_alu12.sv
module oc_alu12
  import oc_alu12_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         link_in,
  output logic [W-1:0] acc_out,
  output logic         link_out,
  output logic         ovf_out,
  output logic [W-1:0] wb_data,
  output logic         wb_en,
  output logic         skip,
  output logic         done
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  logic [W-1:0] oc_sum, la_sum, bu_res, bu_rot;
  logic         oc_ovf, la_ovf, la_link, bu_eq, bu_rskip;

  oc_adder #(.W(W)) u_oc (.a(acc_in), .b(opnd_in), .sum(oc_sum), .ovf(oc_ovf));

  link_adder #(.W(W)) u_la (
    .acc(acc_in), .opnd(opnd_in), .link_i(link_in),
    .sum(la_sum), .link_o(la_link), .ovf(la_ovf)
  );

  bit_unit #(.W(W)) u_bu (
    .op(op_e), .acc(acc_in), .opnd(opnd_in),
    .res(bu_res), .eq(bu_eq), .rot(bu_rot), .rot_skip(bu_rskip)
  );

  logic [W-1:0] acc_n, wb_n;
  logic         link_n, ovf_n, wbe_n, skip_n;

  always_comb begin
    acc_n  = acc_in;
    link_n = link_in;
    ovf_n  = ovf_out;
    wb_n   = opnd_in;
    wbe_n  = 1'b0;
    skip_n = 1'b0;
    case (op_e)
      OP_ADD: begin
        acc_n = oc_sum;
        ovf_n = oc_ovf;
      end
      OP_ADDM: begin
        acc_n = oc_sum;
        ovf_n = oc_ovf;
        wb_n  = oc_sum;
        wbe_n = 1'b1;
      end
      OP_LADD: begin
        acc_n  = la_sum;
        link_n = la_link;
        ovf_n  = la_ovf;
        wb_n   = la_sum;
        wbe_n  = 1'b1;
      end
      OP_CLR, OP_SET, OP_FLIP: acc_n = bu_res;
      OP_EQ:  skip_n = bu_eq;
      OP_ROT: begin
        wb_n   = bu_rot;
        wbe_n  = 1'b1;
        skip_n = bu_rskip;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out  <= '0;
      link_out <= 1'b0;
      ovf_out  <= 1'b0;
      wb_data  <= '0;
      wb_en    <= 1'b0;
      skip     <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      acc_out  <= acc_n;
      link_out <= link_n;
      ovf_out  <= ovf_n;
      wb_data  <= wb_n;
      wb_en    <= wbe_n;
      skip     <= skip_n;
      done     <= 1'b1;
    end else begin
      wb_en <= 1'b0;
      skip  <= 1'b0;
      done  <= 1'b0;
    end
  end

  // R9
  pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && !wb_en && !skip));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(acc_out) && $stable(link_out) && $stable(ovf_out)));

  // R2
  add_link_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_ADD) |=> (link_out == $past(link_in) && !wb_en));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_ADD && (acc_in[W-1] != opnd_in[W-1])) |=> !ovf_out);

  // R7
  eq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_EQ) |=> (acc_out == $past(acc_in) && !wb_en));

  // R8
  rot_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_ROT) |=> (wb_en && skip == !$past(opnd_in[0])));
endmodule

// File: tb/oc_alu12_tb_top.sv
`timescale 1ns/1ps
module oc_alu12_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [3:0]   op = 4'd0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] opnd_in = '0;
  logic         link_in = 1'b0;
  logic [W-1:0] acc_out, wb_data;
  logic         link_out, ovf_out, wb_en, skip, done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  oc_alu12 #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .acc_in(acc_in), .opnd_in(opnd_in), .link_in(link_in),
    .acc_out(acc_out), .link_out(link_out), .ovf_out(ovf_out),
    .wb_data(wb_data), .wb_en(wb_en), .skip(skip), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] y, input logic l);
    @(negedge clk);
    op = o; acc_in = a; opnd_in = y; link_in = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "acc", acc_out, '0);
    chk("R1", "link", {11'd0, link_out}, '0);
    chk("R1", "ovf", {11'd0, ovf_out}, '0);
    chk("R1", "wb_data", wb_data, '0);
    chk("R1", "wb_en/skip/done", {9'd0, wb_en, skip, done}, '0);
  endtask

  task automatic t_ones_add;
    run_op(4'd0, 12'o2435, 12'o5704, 1'b1);
    chk("R2", "sum wrap", acc_out, 12'o0342);
    chk("R2", "link kept", {11'd0, link_out}, 12'd1);
    chk("R2", "no wb", {11'd0, wb_en}, 12'd0);
    chk("R3", "unlike signs", {11'd0, ovf_out}, 12'd0);
    run_op(4'd0, 12'o2435, 12'o1704, 1'b0);
    chk("R2", "sum", acc_out, 12'o4341);
    chk("R3", "pos overflow", {11'd0, ovf_out}, 12'd1);
    run_op(4'd0, 12'o7777, 12'o0001, 1'b0);
    chk("R2", "minus zero plus one", acc_out, 12'o0001);
    chk("R3", "mixed signs", {11'd0, ovf_out}, 12'd0);
    run_op(4'd0, 12'o4000, 12'o4000, 1'b0);
    chk("R2", "neg wrap", acc_out, 12'o0001);
    chk("R3", "neg overflow", {11'd0, ovf_out}, 12'd1);
  endtask

  task automatic t_ovf_hold;
    run_op(4'd0, 12'o3777, 12'o0001, 1'b0);
    chk("R3", "edge overflow", {11'd0, ovf_out}, 12'd1);
    chk("R2", "edge sum", acc_out, 12'o4000);
    run_op(4'd3, 12'o0000, 12'o0000, 1'b0);
    chk("R3", "held by logic op", {11'd0, ovf_out}, 12'd1);
    run_op(4'd0, 12'o0001, 12'o0002, 1'b0);
    chk("R3", "cleared", {11'd0, ovf_out}, 12'd0);
  endtask

  task automatic t_addm;
    run_op(4'd1, 12'o1234, 12'o0001, 1'b0);
    chk("R4", "acc", acc_out, 12'o1235);
    chk("R4", "wb", wb_data, 12'o1235);
    chk("R4", "wb_en", {11'd0, wb_en}, 12'd1);
  endtask

  task automatic t_linkadd;
    run_op(4'd2, 12'o3743, 12'o6517, 1'b1);
    chk("R5", "sum", acc_out, 12'o2463);
    chk("R5", "wb", wb_data, 12'o2463);
    chk("R5", "wb_en", {11'd0, wb_en}, 12'd1);
    chk("R5", "link set", {11'd0, link_out}, 12'd1);
    chk("R5", "ovf", {11'd0, ovf_out}, 12'd0);
    run_op(4'd2, 12'o0000, 12'o0000, 1'b1);
    chk("R5", "sum2", acc_out, 12'o0001);
    chk("R5", "link cleared", {11'd0, link_out}, 12'd0);
    run_op(4'd2, 12'o7777, 12'o0001, 1'b1);
    chk("R5", "sum3", acc_out, 12'o0001);
    chk("R5", "link from step1", {11'd0, link_out}, 12'd1);
    run_op(4'd2, 12'o0001, 12'o7777, 1'b0);
    chk("R5", "sum4", acc_out, 12'o0000);
    chk("R5", "link from step2", {11'd0, link_out}, 12'd1);
    run_op(4'd2, 12'o3777, 12'o0001, 1'b0);
    chk("R5", "ovf step2", {11'd0, ovf_out}, 12'd1);
  endtask

  task automatic t_bitwise;
    run_op(4'd3, 12'o2307, 12'o1616, 1'b1);
    chk("R6", "clear", acc_out, 12'o2101);
    chk("R6", "link kept", {11'd0, link_out}, 12'd1);
    run_op(4'd4, 12'o2307, 12'o1616, 1'b0);
    chk("R6", "set", acc_out, 12'o3717);
    run_op(4'd5, 12'o2307, 12'o1616, 1'b0);
    chk("R6", "flip", acc_out, 12'o3511);
    chk("R6", "no wb/skip", {10'd0, wb_en, skip}, 12'd0);
  endtask

  task automatic t_eq;
    run_op(4'd6, 12'o4567, 12'o4567, 1'b0);
    chk("R7", "skip equal", {11'd0, skip}, 12'd1);
    chk("R7", "acc kept", acc_out, 12'o4567);
    run_op(4'd6, 12'o4567, 12'o4566, 1'b0);
    chk("R7", "no skip", {11'd0, skip}, 12'd0);
    chk("R7", "no wb", {11'd0, wb_en}, 12'd0);
  endtask

  task automatic t_rot;
    run_op(4'd7, 12'o1111, 12'o3725, 1'b0);
    chk("R8", "rotated", wb_data, 12'o5752);
    chk("R8", "no skip", {11'd0, skip}, 12'd0);
    chk("R8", "acc kept", acc_out, 12'o1111);
    run_op(4'd7, 12'o1111, 12'o5752, 1'b0);
    chk("R8", "rotated2", wb_data, 12'o2765);
    chk("R8", "skip", {11'd0, skip}, 12'd1);
    chk("R8", "wb_en", {11'd0, wb_en}, 12'd1);
  endtask

  task automatic t_pulse;
    run_op(4'd7, 12'o0042, 12'o0000, 1'b0);
    chk("R9", "done", {11'd0, done}, 12'd1);
    @(negedge clk);
    chk("R9", "pulses fall", {9'd0, done, wb_en, skip}, 12'd0);
    chk("R9", "acc held", acc_out, 12'o0042);
    chk("R9", "wb held", wb_data, 12'o0000);
  endtask

  task automatic t_reserved;
    run_op(4'd0, 12'o4000, 12'o4000, 1'b0);
    run_op(4'd9, 12'o1357, 12'o0246, 1'b1);
    chk("R10", "acc", acc_out, 12'o1357);
    chk("R10", "link", {11'd0, link_out}, 12'd1);
    chk("R10", "ovf kept", {11'd0, ovf_out}, 12'd1);
    chk("R10", "no wb/skip", {10'd0, wb_en, skip}, 12'd0);
    chk("R10", "done", {11'd0, done}, 12'd1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ones_add();
    t_ovf_hold();
    t_addm();
    t_linkadd();
    t_bitwise();
    t_eq();
    t_rot();
    t_pulse();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule